// File: doc/BRIEF.md
# Microframe Transaction Eligibility for Queue Heads

This block decides, once per microframe, whether a single queue head taken from a USB 2.0 host schedule may run a transaction in the current microframe. The low bits of the frame index select one position in each of two 8-bit masks. The start mask decides start eligibility. The completion mask decides complete-split eligibility. The result is qualified by the endpoint speed, by whether the queue head sits on the periodic or the asynchronous list, and by the overlay's Active and split-pending bits.

The block also classifies the endpoint. It flags an interrupt endpoint, flags a split transaction that a hub must relay, and raises an error for mask settings whose outcome is undefined. The schedule walker pulses the microframe strobe after loading a queue head's fields, and it reads the registered flags one clock later. For high-speed endpoints the transaction direction and type are taken from the overlay's PID code elsewhere; this block supplies only the timing.

Top module: `qh_uframe_elig`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, all five outputs are 0.
- R2: `start_cand` equals the bit of `start_mask` at position `frame_idx[2:0]` for speed codes 00 (full), 01 (low) and 10 (high). The flag may be 1 in several microframes of a frame when several mask bits are set.
- R3: `cmpl_cand` is 1 only when all of the following hold: the speed code is 00 or 01, `on_periodic` is 1, `cmpl_mask[frame_idx[2:0]]` is 1, `ovl_active` is 1 and `split_pending` is 1. A high-speed endpoint never gets a completion candidate.
- R4: `intr_ep` is 1 exactly when `start_mask` is non-zero.
- R5: `split_req` is 1 exactly when `start_mask` is non-zero and the speed code is 00 or 01.
- R6: `cfg_err` is 1 when either of two conditions holds. The first is a speed code of 00 or 01 on the periodic schedule with `cmpl_mask` equal to zero. The second is `on_periodic` at 1 with `start_mask` equal to zero.
- R7: Speed code 11 (reserved) forces both `start_cand` and `cmpl_cand` to 0.
- R8: The outputs load only on a rising clock edge where `uf_strobe` is 1, and they show the result of the inputs present at that edge. On edges where the strobe is 0 they hold their value.
- R9: Bits of `frame_idx` above bit 2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_strobe | input | 1 | Evaluate and load the outputs this cycle |
| frame_idx | input | FIDX_W (14) | Frame index counter; the low 3 bits give the microframe |
| ep_speed | input | 2 | Speed code: 00 full, 01 low, 10 high, 11 reserved |
| on_periodic | input | 1 | 1 = periodic schedule, 0 = asynchronous schedule |
| start_mask | input | MASK_W (8) | Start-eligibility mask per microframe |
| cmpl_mask | input | MASK_W (8) | Complete-split eligibility mask per microframe |
| ovl_active | input | 1 | Overlay Active bit |
| split_pending | input | 1 | Split state shows a complete-split is pending |
| start_cand | output | 1 | Queue head may start a transaction now |
| cmpl_cand | output | 1 | Queue head may run a complete-split now |
| intr_ep | output | 1 | Endpoint is an interrupt endpoint |
| split_req | output | 1 | Transaction must be split through a hub |
| cfg_err | output | 1 | Undefined mask configuration |

## Verification
The assertions take for granted that the inputs are stable across the strobed edge. Their expectations cover only the cycle after a strobe. An unstrobed cycle may change any input freely and must leave the outputs frozen. The stimulus drives inputs only on the falling edge and raises the strobe for exactly one cycle per evaluation. It sweeps all eight microframe positions against random masks, speed codes (the reserved code included), schedule types and upper frame-index bits. Between some strobes it changes the inputs with the strobe low, to show that the outputs hold.

// File: rtl/qhe_pkg.sv
package qhe_pkg;

   typedef enum logic [1:0] {
      SPD_FULL = 2'b00,
      SPD_LOW  = 2'b01,
      SPD_HIGH = 2'b10,
      SPD_RSV  = 2'b11
   } ep_speed_e;

   typedef struct packed {
      logic start;
      logic cmpl;
      logic intr;
      logic split;
      logic err;
   } elig_t;

   function automatic logic needs_split(input ep_speed_e s);
      return (s == SPD_FULL) || (s == SPD_LOW);
   endfunction

endpackage

// File: rtl/qhe_mask_sel.sv
module qhe_mask_sel #(
   parameter int MASK_W = 8,
   parameter int IDX_W  = 3,
   parameter int STYLE  = 0
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_o,
   output logic              any_o
);

   assign any_o = |mask;

   if (STYLE == 0) begin : g_mux
      assign bit_o = mask[idx];
   end else begin : g_decode
      logic [MASK_W-1:0] dec;
      for (genvar g = 0; g < MASK_W; g++) begin : g_bit
         assign dec[g] = (idx == IDX_W'(g));
      end
      assign bit_o = |(dec & mask);
   end

endmodule

// File: rtl/qhe_decode.sv
module qhe_decode
   import qhe_pkg::*;
(
   input  logic [1:0] speed,
   input  logic       periodic,
   input  logic       s_bit,
   input  logic       s_any,
   input  logic       c_bit,
   input  logic       c_any,
   input  logic       active,
   input  logic       pending,
   output elig_t      res
);

   ep_speed_e spd;
   logic      split_dev;
   logic      cmpl_rules;

   assign spd        = ep_speed_e'(speed);
   assign split_dev  = needs_split(spd);
   assign cmpl_rules = split_dev && periodic;

   always_comb begin
      res       = '0;
      res.start = s_bit && (spd != SPD_RSV);
      res.cmpl  = cmpl_rules && c_bit && active && pending;
      res.intr  = s_any;
      res.split = s_any && split_dev;
      res.err   = (cmpl_rules && !c_any) || (periodic && !s_any);
   end

endmodule

// File: rtl/qhe_hold_reg.sv
module qhe_hold_reg
   import qhe_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  elig_t d,
   output elig_t q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/qh_uframe_elig.sv
module qh_uframe_elig
   import qhe_pkg::*;
#(
   parameter int MASK_W    = 8,
   parameter int FIDX_W    = 14,
   parameter int SEL_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uf_strobe,
   input  logic [FIDX_W-1:0] frame_idx,
   input  logic [1:0]        ep_speed,
   input  logic              on_periodic,
   input  logic [MASK_W-1:0] start_mask,
   input  logic [MASK_W-1:0] cmpl_mask,
   input  logic              ovl_active,
   input  logic              split_pending,
   output logic              start_cand,
   output logic              cmpl_cand,
   output logic              intr_ep,
   output logic              split_req,
   output logic              cfg_err
);

   localparam int IDX_W = $clog2(MASK_W);

   if (MASK_W < 2 || (1 << IDX_W) != MASK_W) begin : g_bad_mask
      $error("MASK_W must be a power of two of at least 2");
   end
   if (FIDX_W <= IDX_W) begin : g_bad_fidx
      $error("FIDX_W must exceed the microframe index width");
   end
   if (SEL_STYLE != 0 && SEL_STYLE != 1) begin : g_bad_style
      $error("SEL_STYLE must be 0 or 1");
   end

   logic [IDX_W-1:0] uidx;
   logic             unused_hi;
   logic             s_bit, s_any, c_bit, c_any;
   elig_t            nxt, cur;

   assign uidx      = frame_idx[IDX_W-1:0];
   assign unused_hi = ^frame_idx[FIDX_W-1:IDX_W];

   qhe_mask_sel #(.MASK_W(MASK_W), .IDX_W(IDX_W), .STYLE(SEL_STYLE)) u_ssel (
      .mask(start_mask), .idx(uidx), .bit_o(s_bit), .any_o(s_any)
   );

   qhe_mask_sel #(.MASK_W(MASK_W), .IDX_W(IDX_W), .STYLE(SEL_STYLE)) u_csel (
      .mask(cmpl_mask), .idx(uidx), .bit_o(c_bit), .any_o(c_any)
   );

   qhe_decode u_dec (
      .speed(ep_speed), .periodic(on_periodic),
      .s_bit(s_bit), .s_any(s_any), .c_bit(c_bit), .c_any(c_any),
      .active(ovl_active), .pending(split_pending), .res(nxt)
   );

   qhe_hold_reg u_reg (
      .clk(clk), .rst_n(rst_n), .load(uf_strobe), .d(nxt), .q(cur)
   );

   assign start_cand = cur.start;
   assign cmpl_cand  = cur.cmpl;
   assign intr_ep    = cur.intr;
   assign split_req  = cur.split;
   assign cfg_err    = cur.err;

   p_rsv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_strobe && ep_speed == 2'b11) |=> (!start_cand && !cmpl_cand));

   p_cmpl_scope_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_strobe && !(on_periodic && ep_speed[1] == 1'b0)) |=> !cmpl_cand);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !uf_strobe |=> $stable({start_cand, cmpl_cand, intr_ep, split_req, cfg_err}));

   p_start_intr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_cand |-> intr_ep);

   p_split_intr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      split_req |-> intr_ep);

   p_empty_start_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_strobe && on_periodic && start_mask == '0) |=> cfg_err);

endmodule

// File: tb/sim_qh_uframe_elig.sv
module sim_qh_uframe_elig;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        uf_strobe = 1'b0;
   logic [13:0] frame_idx = '0;
   logic [1:0]  ep_speed = '0;
   logic        on_periodic = 1'b0;
   logic [7:0]  start_mask = '0;
   logic [7:0]  cmpl_mask = '0;
   logic        ovl_active = 1'b0;
   logic        split_pending = 1'b0;
   logic        start_cand, cmpl_cand, intr_ep, split_req, cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   qh_uframe_elig u0 (
      .clk(clk), .rst_n(rst_n), .uf_strobe(uf_strobe), .frame_idx(frame_idx),
      .ep_speed(ep_speed), .on_periodic(on_periodic), .start_mask(start_mask),
      .cmpl_mask(cmpl_mask), .ovl_active(ovl_active), .split_pending(split_pending),
      .start_cand(start_cand), .cmpl_cand(cmpl_cand), .intr_ep(intr_ep),
      .split_req(split_req), .cfg_err(cfg_err)
   );

   function automatic logic [4:0] ref_model(input logic [1:0] s, input logic p,
      input logic [7:0] sm, input logic [7:0] cm, input logic a, input logic pd,
      input logic [13:0] fi);
      logic [2:0] ix;
      logic fsls, rules, st, cp, it, sp, er;
      ix    = fi[2:0];
      fsls  = (s == 2'b00) || (s == 2'b01);
      rules = fsls && p;
      st    = sm[ix] && (s != 2'b11);
      cp    = rules && cm[ix] && a && pd;
      it    = (sm != 8'd0);
      sp    = it && fsls;
      er    = (rules && cm == 8'd0) || (p && sm == 8'd0);
      return {st, cp, it, sp, er};
   endfunction

   function automatic logic [4:0] outs();
      return {start_cand, cmpl_cand, intr_ep, split_req, cfg_err};
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_all(input logic [4:0] e, input string ctx);
      logic [4:0] a;
      a = outs();
      chk({"R2 start_cand ", ctx}, a[4], e[4]);
      chk({"R3 cmpl_cand ", ctx},  a[3], e[3]);
      chk({"R4 intr_ep ", ctx},    a[2], e[2]);
      chk({"R5 split_req ", ctx},  a[1], e[1]);
      chk({"R6 cfg_err ", ctx},    a[0], e[0]);
   endtask

   task automatic apply(input logic [1:0] s, input logic p, input logic [7:0] sm,
      input logic [7:0] cm, input logic a, input logic pd, input logic [13:0] fi);
      @(negedge clk);
      ep_speed = s; on_periodic = p; start_mask = sm; cmpl_mask = cm;
      ovl_active = a; split_pending = pd; frame_idx = fi;
      uf_strobe = 1'b1;
      @(negedge clk);
      uf_strobe = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [4:0] e, snap;
      void'($urandom(32'd20240607));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 outputs in reset", |outs(), 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", |outs(), 1'b0);

      // R2: multi-bit start mask, sweep all microframes, high speed async
      for (int i = 0; i < 8; i++) begin
         apply(2'b10, 1'b0, 8'b1000_0101, 8'hFF, 1'b1, 1'b1, 14'(i));
         chk("R2 multi-bit start mask", start_cand, (8'b1000_0101 >> i) & 1'b1);
      end

      // R3: high speed never completes even with everything set
      apply(2'b10, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, 14'd3);
      chk("R3 high speed no complete", cmpl_cand, 1'b0);
      // R3: full speed periodic completes, but not without Active
      apply(2'b00, 1'b1, 8'h01, 8'h08, 1'b1, 1'b1, 14'd3);
      chk("R3 complete eligible", cmpl_cand, 1'b1);
      apply(2'b00, 1'b1, 8'h01, 8'h08, 1'b0, 1'b1, 14'd3);
      chk("R3 complete needs active", cmpl_cand, 1'b0);
      apply(2'b01, 1'b0, 8'h01, 8'h08, 1'b1, 1'b1, 14'd3);
      chk("R3 complete needs periodic", cmpl_cand, 1'b0);

      // R6: both undefined configurations
      apply(2'b01, 1'b1, 8'h04, 8'h00, 1'b1, 1'b0, 14'd2);
      chk("R6 zero completion mask", cfg_err, 1'b1);
      apply(2'b10, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 14'd2);
      chk("R6 zero start mask periodic", cfg_err, 1'b1);
      apply(2'b10, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 14'd2);
      chk("R6 async zero masks fine", cfg_err, 1'b0);

      // R7: reserved speed
      apply(2'b11, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, 14'd5);
      chk("R7 reserved start", start_cand, 1'b0);
      chk("R7 reserved complete", cmpl_cand, 1'b0);

      // R9: upper frame index bits ignored
      apply(2'b00, 1'b1, 8'h20, 8'h20, 1'b1, 1'b1, 14'h3FFD);
      chk("R9 upper bits start", start_cand, 1'b1);
      chk("R9 upper bits complete", cmpl_cand, 1'b1);
      apply(2'b00, 1'b1, 8'h20, 8'h20, 1'b1, 1'b1, 14'h3FF9);
      chk("R9 upper bits other uframe", start_cand, 1'b0);

      // Random sweep, R8 hold checks interleaved
      for (int n = 0; n < 60; n++) begin
         for (int i = 0; i < 8; i++) begin
            logic [1:0] s; logic p, a, pd; logic [7:0] sm, cm; logic [13:0] fi;
            s  = 2'($urandom_range(0, 3));
            p  = 1'($urandom);
            sm = ($urandom_range(0, 5) == 0) ? 8'd0 : 8'($urandom);
            cm = ($urandom_range(0, 5) == 0) ? 8'd0 : 8'($urandom);
            a  = 1'($urandom);
            pd = 1'($urandom);
            fi = {11'($urandom), 3'(i)};
            apply(s, p, sm, cm, a, pd, fi);
            e = ref_model(s, p, sm, cm, a, pd, fi);
            chk_all(e, "random");
            if (s == 2'b11) chk("R7 random reserved", start_cand | cmpl_cand, 1'b0);
            if ((i & 3) == 0) begin
               snap = outs();
               @(negedge clk);
               start_mask = ~start_mask; cmpl_mask = ~cmpl_mask;
               on_periodic = ~on_periodic; ep_speed = ep_speed ^ 2'b10;
               frame_idx = frame_idx + 14'd1;
               @(negedge clk);
               chk("R8 hold without strobe", outs() != snap, 1'b0);
            end
         end
      end

      finish_run();
   end

endmodule